// File: doc/BRIEF.md
# Word and Byte Memory Port Controller

This block sits between a microcoded datapath and an external memory and gives the datapath two independent ways to reach it. The word port carries data: an address register holds a word address, and a data register supplies write data or receives read data. The fetch port carries the program stream: a program counter holds a byte address, and an 8-bit buffer receives the byte read from it, offered to the datapath both zero-extended and sign-extended.

Each microinstruction may raise a read strobe, a write strobe and a fetch strobe. In the cycle a strobe is raised, the datapath may also load the address register (and, for writes, the data register) in the same cycle. The memory request goes out one cycle later, the returned value is captured at the end of that cycle, and the following microinstruction can use it. Since a request is only a one-cycle record, the microinstruction issued while a read is in flight is free to do unrelated work, including loading a new address and issuing the next read.

Top module: `mem_port_ctrl`

## Requirements
- R1: After synchronous reset the address register, data register, program counter and byte buffer read zero, and no memory strobe or conflict flag is high.
- R2: A read strobe in cycle N makes `dmem_rd` high in cycle N+1 only, and the data register shows the word returned in N+1 from cycle N+2 onward.
- R3: The memory address for the word port is the word address shifted left by 2 with the two upper bits dropped, so its low two bits are always zero (word address 0x4000_0005 goes out as 0x0000_0014).
- R4: A write strobe (read low) in cycle N makes `dmem_wr` high in cycle N+1 only, with the shifted address and the data register value of that cycle on `dmem_wdata`; both registers may be loaded in cycle N.
- R5: A fetch strobe in cycle N makes `imem_rd` high in cycle N+1 with the program counter as byte address, and the byte buffer shows the returned byte from cycle N+2.
- R6: `mbr_zx` is the byte buffer with zeros above bit 7; `mbr_sx` is the byte buffer with bit 7 copied into bits 31..8.
- R7: Read and write strobes in the same cycle raise `rw_err` in the next cycle only; the read is carried out and no write reaches memory.
- R8: A microinstruction in cycle N+1 may load a new word address and issue another read without disturbing the one in flight; each read returns the word at its own address in consecutive cycles.
- R9: The data register changes only on a read completion or a datapath load, and a completing read wins when both fall on one edge; the byte buffer changes only on a fetch completion.
- R10: `dmem_rd` and `dmem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mar_we | input | 1 | Load word address register |
| mar_d | input | 32 | Word address to load |
| mdr_we | input | 1 | Load data register from datapath |
| mdr_d | input | 32 | Data word to load |
| pc_we | input | 1 | Load program counter |
| pc_d | input | 32 | Byte address to load |
| rd_req | input | 1 | Word read strobe |
| wr_req | input | 1 | Word write strobe |
| fetch_req | input | 1 | Byte fetch strobe |
| mar_q | output | 32 | Word address register |
| mdr_q | output | 32 | Data register |
| pc_q | output | 32 | Program counter |
| mbr_q | output | 8 | Fetched byte buffer |
| mbr_zx | output | 32 | Byte buffer, zero-extended |
| mbr_sx | output | 32 | Byte buffer, sign-extended |
| rw_err | output | 1 | Read and write requested together |
| dmem_addr | output | 32 | Byte address to word memory |
| dmem_rd | output | 1 | Word memory read |
| dmem_wr | output | 1 | Word memory write |
| dmem_wdata | output | 32 | Word memory write data |
| dmem_rdata | input | 32 | Word memory read data, valid in the cycle of `dmem_rd` |
| imem_addr | output | 32 | Byte address to program memory |
| imem_rd | output | 1 | Program memory read |
| imem_rdata | input | 8 | Program memory byte, valid in the cycle of `imem_rd` |

## Verification
The bench builds the block with its defaults: 32-bit words and 32-bit addresses, which makes the shift amount 2 and leaves 24 bits of extension above the fetched byte. At that width a word address with bit 30 set shows the upper bits falling off the shifted address, and fetch addresses are chosen so the returned byte has bit 7 both clear and set. The sixteen-word model memory is enough to place overlapping reads, a read colliding with a datapath load of the data register, and a refused write on distinct words whose contents the bench knows.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int BYTE_W = 8;

    // Strobes carried by one microinstruction
    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
    } mem_req_t;

    // Operation presented on the word port in the cycle after the strobe
    typedef enum logic [1:0] {
        DOP_IDLE  = 2'd0,
        DOP_READ  = 2'd1,
        DOP_WRITE = 2'd2
    } dop_e;

    // A read wins over a simultaneous write; the write is dropped.
    function automatic dop_e decode_dop(input logic rd, input logic wr);
        if (rd)
            return DOP_READ;
        else if (wr)
            return DOP_WRITE;
        else
            return DOP_IDLE;
    endfunction

    function automatic logic is_conflict(input mem_req_t r);
        return r.rd && r.wr;
    endfunction

endpackage

// File: rtl/mpc_data_port.sv
module mpc_data_port
    import mpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mar_we,
    input  logic [ADDR_W-1:0] mar_d,
    input  logic              mdr_we,
    input  logic [DATA_W-1:0] mdr_d,
    input  mem_req_t          req,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q,
    output logic              rw_err,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic              dmem_rd,
    output logic              dmem_wr,
    output logic [DATA_W-1:0] dmem_wdata,
    input  logic [DATA_W-1:0] dmem_rdata
);

    localparam int LANE_SH = $clog2(DATA_W / BYTE_W);

    dop_e op_now;
    dop_e op_q;
    logic conf_q;

    always_comb begin
        op_now = decode_dop(req.rd, req.wr);
    end

    // Address register and the one-cycle request record
    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q  <= '0;
            op_q   <= DOP_IDLE;
            conf_q <= 1'b0;
        end else begin
            if (mar_we)
                mar_q <= mar_d;
            op_q   <= op_now;
            conf_q <= is_conflict(req);
        end
    end

    // Data register: completing read has priority over a datapath load
    always_ff @(posedge clk) begin
        if (rst)
            mdr_q <= '0;
        else if (op_q == DOP_READ)
            mdr_q <= dmem_rdata;
        else if (mdr_we)
            mdr_q <= mdr_d;
    end

    assign dmem_addr  = {mar_q[ADDR_W-LANE_SH-1:0], {LANE_SH{1'b0}}};
    assign dmem_rd    = (op_q == DOP_READ);
    assign dmem_wr    = (op_q == DOP_WRITE);
    assign dmem_wdata = mdr_q;
    assign rw_err     = conf_q;

endmodule

// File: rtl/mpc_fetch_port.sv
module mpc_fetch_port
    import mpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_we,
    input  logic [ADDR_W-1:0] pc_d,
    input  logic              fetch,
    output logic [ADDR_W-1:0] pc_q,
    output logic [BYTE_W-1:0] mbr_q,
    output logic [ADDR_W-1:0] imem_addr,
    output logic              imem_rd,
    input  logic [BYTE_W-1:0] imem_rdata
);

    logic fetch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            fetch_q <= 1'b0;
        end else begin
            if (pc_we)
                pc_q <= pc_d;
            fetch_q <= fetch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mbr_q <= '0;
        else if (fetch_q)
            mbr_q <= imem_rdata;
    end

    assign imem_addr = pc_q;
    assign imem_rd   = fetch_q;

endmodule

// File: rtl/mpc_mbr_ext.sv
module mpc_mbr_ext
    import mpc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [BYTE_W-1:0] mbr,
    output logic [DATA_W-1:0] zx,
    output logic [DATA_W-1:0] sx
);

    generate
        if (DATA_W > BYTE_W) begin : g_wide
            localparam int FILL_W = DATA_W - BYTE_W;
            assign zx = {{FILL_W{1'b0}}, mbr};
            assign sx = {{FILL_W{mbr[BYTE_W-1]}}, mbr};
        end else begin : g_narrow
            assign zx = mbr;
            assign sx = mbr;
        end
    endgenerate

endmodule

// File: rtl/mem_port_ctrl.sv
module mem_port_ctrl
    import mpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mar_we,
    input  logic [ADDR_W-1:0] mar_d,
    input  logic              mdr_we,
    input  logic [DATA_W-1:0] mdr_d,
    input  logic              pc_we,
    input  logic [ADDR_W-1:0] pc_d,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              fetch_req,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [7:0]        mbr_q,
    output logic [DATA_W-1:0] mbr_zx,
    output logic [DATA_W-1:0] mbr_sx,
    output logic              rw_err,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic              dmem_rd,
    output logic              dmem_wr,
    output logic [DATA_W-1:0] dmem_wdata,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic [ADDR_W-1:0] imem_addr,
    output logic              imem_rd,
    input  logic [7:0]        imem_rdata
);

    mem_req_t req;

    always_comb begin
        req.rd    = rd_req;
        req.wr    = wr_req;
        req.fetch = fetch_req;
    end

    mpc_data_port #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) data_port_i (
        .clk       (clk),
        .rst       (rst),
        .mar_we    (mar_we),
        .mar_d     (mar_d),
        .mdr_we    (mdr_we),
        .mdr_d     (mdr_d),
        .req       (req),
        .mar_q     (mar_q),
        .mdr_q     (mdr_q),
        .rw_err    (rw_err),
        .dmem_addr (dmem_addr),
        .dmem_rd   (dmem_rd),
        .dmem_wr   (dmem_wr),
        .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata)
    );

    mpc_fetch_port #(
        .ADDR_W(ADDR_W)
    ) fetch_port_i (
        .clk       (clk),
        .rst       (rst),
        .pc_we     (pc_we),
        .pc_d      (pc_d),
        .fetch     (req.fetch),
        .pc_q      (pc_q),
        .mbr_q     (mbr_q),
        .imem_addr (imem_addr),
        .imem_rd   (imem_rd),
        .imem_rdata(imem_rdata)
    );

    mpc_mbr_ext #(
        .DATA_W(DATA_W)
    ) mbr_ext_i (
        .mbr(mbr_q),
        .zx (mbr_zx),
        .sx (mbr_sx)
    );

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic              wr_req,
    input logic              fetch_req,
    input logic              mdr_we,
    input logic [DATA_W-1:0] mdr_q,
    input logic [7:0]        mbr_q,
    input logic              rw_err,
    input logic [ADDR_W-1:0] dmem_addr,
    input logic              dmem_rd,
    input logic              dmem_wr,
    input logic [DATA_W-1:0] dmem_rdata,
    input logic              imem_rd,
    input logic [7:0]        imem_rdata
);

    assert_read_issue_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> dmem_rd);

    assert_read_capture_R2: assert property (@(posedge clk) disable iff (rst)
        dmem_rd |=> (mdr_q == $past(dmem_rdata)));

    assert_addr_align_R3: assert property (@(posedge clk) disable iff (rst)
        (dmem_rd || dmem_wr) |-> (dmem_addr[1:0] == 2'b00));

    assert_write_issue_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !rd_req) |=> dmem_wr);

    assert_fetch_issue_R5: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> imem_rd);

    assert_fetch_capture_R5: assert property (@(posedge clk) disable iff (rst)
        imem_rd |=> (mbr_q == $past(imem_rdata)));

    assert_conflict_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req) |=> (rw_err && dmem_rd && !dmem_wr));

    assert_mdr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!dmem_rd && !mdr_we) |=> $stable(mdr_q));

    assert_mbr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !imem_rd |=> $stable(mbr_q));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr));

endmodule

bind mem_port_ctrl mpc_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .fetch_req (fetch_req),
    .mdr_we    (mdr_we),
    .mdr_q     (mdr_q),
    .mbr_q     (mbr_q),
    .rw_err    (rw_err),
    .dmem_addr (dmem_addr),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .dmem_rdata(dmem_rdata),
    .imem_rd   (imem_rd),
    .imem_rdata(imem_rdata)
);

// File: tb/mem_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module mem_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mar_we = 1'b0;
    logic [31:0] mar_d = '0;
    logic        mdr_we = 1'b0;
    logic [31:0] mdr_d = '0;
    logic        pc_we = 1'b0;
    logic [31:0] pc_d = '0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] mar_q, mdr_q, pc_q, mbr_zx, mbr_sx;
    logic [7:0]  mbr_q;
    logic        rw_err;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata, imem_addr;
    logic        dmem_rd, dmem_wr, imem_rd;
    logic [7:0]  imem_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mem_port_ctrl dut_i (
        .clk(clk), .rst(rst),
        .mar_we(mar_we), .mar_d(mar_d),
        .mdr_we(mdr_we), .mdr_d(mdr_d),
        .pc_we(pc_we), .pc_d(pc_d),
        .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
        .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q), .mbr_q(mbr_q),
        .mbr_zx(mbr_zx), .mbr_sx(mbr_sx), .rw_err(rw_err),
        .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_rdata(imem_rdata)
    );

    // Behavioural memories
    function automatic logic [31:0] init_word(input int i);
        return 32'hA500_0000 ^ (i * 32'h0001_0203);
    endfunction

    function automatic logic [7:0] prog_byte(input logic [31:0] a);
        return a[7:0] ^ 8'hA5 ^ a[15:8];
    endfunction

    logic [31:0] dmem [16];

    initial begin
        for (int i = 0; i < 16; i++)
            dmem[i] = init_word(i);
    end

    always @(posedge clk)
        if (dmem_wr)
            dmem[dmem_addr[5:2]] <= dmem_wdata;

    assign dmem_rdata = dmem_rd ? dmem[dmem_addr[5:2]] : 32'h0;
    assign imem_rdata = imem_rd ? prog_byte(imem_addr) : 8'h00;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        mar_we = 0; mdr_we = 0; pc_we = 0;
        rd_req = 0; wr_req = 0; fetch_req = 0;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // R1
    task automatic t_reset();
        check("R1", "mar_q", mar_q, 0);
        check("R1", "mdr_q", mdr_q, 0);
        check("R1", "pc_q", pc_q, 0);
        check("R1", "mbr_q", {24'h0, mbr_q}, 0);
        check("R1", "strobes", {29'h0, dmem_rd, dmem_wr, imem_rd}, 0);
        check("R1", "rw_err", {31'h0, rw_err}, 0);
    endtask

    // R2, R3
    task automatic t_read();
        mar_we = 1; mar_d = 32'h4000_0005; rd_req = 1;
        tick(); idle();
        check("R2", "dmem_rd in N+1", {31'h0, dmem_rd}, 1);
        check("R3", "shifted address", dmem_addr, 32'h0000_0014);
        check("R2", "mar_q loaded", mar_q, 32'h4000_0005);
        tick();
        check("R2", "mdr_q in N+2", mdr_q, init_word(5));
        check("R2", "dmem_rd single", {31'h0, dmem_rd}, 0);
    endtask

    // R4, R10
    task automatic t_write();
        mar_we = 1; mar_d = 32'd9; mdr_we = 1; mdr_d = 32'hDEAD_BEEF; wr_req = 1;
        tick(); idle();
        check("R4", "dmem_wr in N+1", {31'h0, dmem_wr}, 1);
        check("R10", "no read with write", {31'h0, dmem_rd}, 0);
        check("R4", "write address", dmem_addr, 32'h0000_0024);
        check("R4", "write data", dmem_wdata, 32'hDEAD_BEEF);
        tick();
        check("R4", "dmem_wr single", {31'h0, dmem_wr}, 0);
        rd_req = 1;
        tick(); idle();
        tick();
        check("R4", "word written", mdr_q, 32'hDEAD_BEEF);
    endtask

    // R5, R6
    task automatic t_fetch(input logic [31:0] pc);
        logic [7:0] b;
        b = prog_byte(pc);
        pc_we = 1; pc_d = pc; fetch_req = 1;
        tick(); idle();
        check("R5", "imem_rd in N+1", {31'h0, imem_rd}, 1);
        check("R5", "imem_addr", imem_addr, pc);
        tick();
        check("R5", "mbr_q in N+2", {24'h0, mbr_q}, {24'h0, b});
        check("R5", "imem_rd single", {31'h0, imem_rd}, 0);
        check("R6", "mbr_zx", mbr_zx, {24'h0, b});
        check("R6", "mbr_sx", mbr_sx, {{24{b[7]}}, b});
    endtask

    // R7
    task automatic t_conflict();
        mar_we = 1; mar_d = 32'd3; mdr_we = 1; mdr_d = 32'h1234_5678;
        rd_req = 1; wr_req = 1;
        tick(); idle();
        check("R7", "rw_err raised", {31'h0, rw_err}, 1);
        check("R7", "write suppressed", {31'h0, dmem_wr}, 0);
        check("R7", "read proceeds", {31'h0, dmem_rd}, 1);
        check("R7", "read address", dmem_addr, 32'h0000_000C);
        tick();
        check("R7", "rw_err one cycle", {31'h0, rw_err}, 0);
        check("R7", "read data", mdr_q, init_word(3));
        mdr_we = 1; mdr_d = 32'h0;
        tick(); idle();
        rd_req = 1;
        tick(); idle();
        tick();
        check("R7", "memory untouched", mdr_q, init_word(3));
    endtask

    // R8
    task automatic t_overlap();
        mar_we = 1; mar_d = 32'd6; rd_req = 1;
        tick();
        mar_we = 1; mar_d = 32'd7; rd_req = 1;
        check("R8", "first read addr", dmem_addr, 32'h0000_0018);
        tick(); idle();
        check("R8", "first word", mdr_q, init_word(6));
        check("R8", "second read issued", {31'h0, dmem_rd}, 1);
        check("R8", "second read addr", dmem_addr, 32'h0000_001C);
        tick();
        check("R8", "second word", mdr_q, init_word(7));
        check("R8", "reads drained", {31'h0, dmem_rd}, 0);
    endtask

    // R9
    task automatic t_priority();
        logic [7:0] held;
        mar_we = 1; mar_d = 32'd2; rd_req = 1;
        tick(); idle();
        mdr_we = 1; mdr_d = 32'h5555_AAAA;
        tick(); idle();
        check("R9", "read beats load", mdr_q, init_word(2));
        mdr_we = 1; mdr_d = 32'h0F0F_0F0F;
        tick(); idle();
        check("R9", "datapath load", mdr_q, 32'h0F0F_0F0F);
        tick();
        check("R9", "mdr holds", mdr_q, 32'h0F0F_0F0F);
        held = prog_byte(32'h0000_0025);
        pc_we = 1; pc_d = 32'h0000_0077;
        tick(); idle();
        tick();
        check("R9", "pc loaded", pc_q, 32'h0000_0077);
        check("R9", "mbr holds without fetch", {24'h0, mbr_q}, {24'h0, held});
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_read();
        t_write();
        t_fetch(32'h0000_01A0);
        t_fetch(32'h0000_0025);
        t_conflict();
        t_overlap();
        t_priority();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule